// File: doc/BRIEF.md
# Condition Flag Register and Branch Resolver

This block keeps the four condition flags of a small 16-bit processor (zero, carry, negative, overflow) and decides, each cycle, whether the instruction in hand redirects control flow. The flags can be loaded straight from the ALU's flag outputs, derived from the value being written back, or left alone. The choice is made by a two-bit update mode that the decoder supplies.

A conditional branch supplies a four-bit mask that picks a subset of the flags. The branch is taken when any picked flag is set in the register as it stands at the start of the cycle. An unconditional jump redirects whatever the flags hold. In both cases the redirect target is the instruction's 16-bit immediate, passed through unchanged. Flag vectors and masks share one bit order: Z at bit 3, C at bit 2, N at bit 1, V at bit 0.

Top module: `ccr_branch_unit`

## Requirements
- R1: While `rst_n` is low, the flag register reads 0000, and it takes that value as soon as reset is asserted, independent of the clock.
- R2: With `upd_mode` = 0 (ALU), the flag register takes `alu_flags` at the next rising clock edge, with every bit in the same position.
- R3: With `upd_mode` = 1 (write-back), at the next rising edge Z (bit 3) becomes 1 exactly when `wb_value` is zero, N (bit 1) becomes `wb_value[15]`, and C (bit 2) and V (bit 0) become 0.
- R4: With `upd_mode` = 2 (hold) or 3 (reserved, treated as hold), the flag register keeps its value across the clock edge.
- R5: With `is_jump` high, `redirect` is 1 for every flag value and every mask.
- R6: With `is_branch` high and `is_jump` low, `redirect` is 1 exactly when `cond_mask & flags` is non-zero. The flags used are those held at the start of the cycle, so an update in the same cycle is not seen. Example masks: zero 1000, carry 0100, negative 0010, overflow 0001, zero-or-negative 1010.
- R7: With `is_branch` and `is_jump` both low, `redirect` is 0 for any mask and any flag value.
- R8: `redirect_pc` always equals `imm_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_mode | input | 2 | Flag update mode: 0 ALU, 1 write-back, 2 hold, 3 hold |
| alu_flags | input | 4 | Flags from the ALU, order {Z,C,N,V} |
| wb_value | input | 16 | Value being written back |
| cond_mask | input | 4 | Branch flag select, order {Z,C,N,V} |
| is_branch | input | 1 | Conditional branch qualifier |
| is_jump | input | 1 | Unconditional jump qualifier |
| imm_target | input | 16 | Instruction immediate, used as the target |
| flags | output | 4 | Current flag register, order {Z,C,N,V} |
| redirect | output | 1 | Control flow is redirected this cycle |
| redirect_pc | output | 16 | Redirect target |

## Verification
The hardest case to reach is a branch issued in the same cycle as a flag update, because the outcome must follow the old flags and not the incoming ones. The bench first loads a known flag value through ALU mode. It then issues a branch together with an ALU update whose flags would reverse the decision, and samples `redirect` before the edge. It samples the register after the edge to confirm the update landed. The main sweep loads each of the 16 flag values and crosses it with all 16 masks and all four qualifier pairs.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned NFLAG  = 4;
  localparam int unsigned BIT_Z  = 3;
  localparam int unsigned BIT_C  = 2;
  localparam int unsigned BIT_N  = 1;
  localparam int unsigned BIT_V  = 0;

  typedef enum logic [1:0] {
    UPD_ALU  = 2'd0,
    UPD_WB   = 2'd1,
    UPD_HOLD = 2'd2,
    UPD_RSVD = 2'd3
  } upd_mode_e;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/ccr_flag_next.sv
module ccr_flag_next
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [1:0]        mode_i,
  input  flag_vec_t         alu_flags_i,
  input  logic [DATA_W-1:0] wb_value_i,
  output flag_vec_t         next_o,
  output logic              load_o
);
  localparam int unsigned SIGN_BIT = DATA_W - 1;

  flag_vec_t wb_flags;

  always_comb begin
    wb_flags        = '0;
    wb_flags[BIT_Z] = (wb_value_i == '0);
    wb_flags[BIT_N] = wb_value_i[SIGN_BIT];
  end

  always_comb begin
    next_o = '0;
    load_o = 1'b0;
    unique case (upd_mode_e'(mode_i))
      UPD_ALU: begin
        next_o = alu_flags_i;
        load_o = 1'b1;
      end
      UPD_WB: begin
        next_o = wb_flags;
        load_o = 1'b1;
      end
      default: begin
        next_o = '0;
        load_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ccr_flag_reg.sv
module ccr_flag_reg
  import ccr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  flag_vec_t d_i,
  output flag_vec_t q_o
);
  flag_vec_t q_r;
  flag_vec_t q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/ccr_redirect_eval.sv
module ccr_redirect_eval
  import ccr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  flag_vec_t         flags_i,
  input  flag_vec_t         mask_i,
  input  logic              is_branch_i,
  input  logic              is_jump_i,
  input  logic [ADDR_W-1:0] imm_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] target_o
);
  flag_vec_t hit;
  logic      cond_true;

  for (genvar g = 0; g < NFLAG; g++) begin : g_hit
    assign hit[g] = mask_i[g] & flags_i[g];
  end

  assign cond_true  = |hit;
  assign redirect_o = is_jump_i | (is_branch_i & cond_true);
  assign target_o   = imm_i;
endmodule

// File: rtl/ccr_branch_unit.sv
module ccr_branch_unit
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        upd_mode,
  input  logic [3:0]        alu_flags,
  input  logic [DATA_W-1:0] wb_value,
  input  logic [3:0]        cond_mask,
  input  logic              is_branch,
  input  logic              is_jump,
  input  logic [ADDR_W-1:0] imm_target,
  output logic [3:0]        flags,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_pc
);
  flag_vec_t flag_d;
  flag_vec_t flag_q;
  logic      flag_en;

  ccr_flag_next #(.DATA_W(DATA_W)) u_next (
    .mode_i      (upd_mode),
    .alu_flags_i (alu_flags),
    .wb_value_i  (wb_value),
    .next_o      (flag_d),
    .load_o      (flag_en)
  );

  ccr_flag_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (flag_en),
    .d_i   (flag_d),
    .q_o   (flag_q)
  );

  ccr_redirect_eval #(.ADDR_W(ADDR_W)) u_eval (
    .flags_i     (flag_q),
    .mask_i      (cond_mask),
    .is_branch_i (is_branch),
    .is_jump_i   (is_jump),
    .imm_i       (imm_target),
    .redirect_o  (redirect),
    .target_o    (redirect_pc)
  );

  assign flags = flag_q;
endmodule

// File: rtl/ccr_branch_unit_chk.sv
module ccr_branch_unit_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        upd_mode,
  input logic [3:0]        alu_flags,
  input logic [DATA_W-1:0] wb_value,
  input logic [3:0]        cond_mask,
  input logic              is_branch,
  input logic              is_jump,
  input logic [ADDR_W-1:0] imm_target,
  input logic [3:0]        flags,
  input logic              redirect,
  input logic [ADDR_W-1:0] redirect_pc
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (flags == 4'b0000);
    end
  end

  assert_alu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_mode == 2'd0 |=> flags == $past(alu_flags));

  assert_wb_derive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_mode == 2'd1 |=> (flags[2] == 1'b0) && (flags[0] == 1'b0) &&
      (flags[3] == ($past(wb_value) == '0)) && (flags[1] == $past(wb_value[DATA_W-1])));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_mode[1] |=> $stable(flags));

  assert_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_jump |-> redirect);

  assert_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !is_jump) |-> (redirect == ((cond_mask & flags) != 4'b0000)));

  assert_no_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_branch && !is_jump) |-> !redirect);

  assert_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_pc == imm_target);
endmodule

bind ccr_branch_unit ccr_branch_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_ccr_branch_unit.sv
`timescale 1ns/1ps
module sim_ccr_branch_unit;
  logic        clk;
  logic        rst_n;
  logic [1:0]  upd_mode;
  logic [3:0]  alu_flags;
  logic [15:0] wb_value;
  logic [3:0]  cond_mask;
  logic        is_branch;
  logic        is_jump;
  logic [15:0] imm_target;
  logic [3:0]  flags;
  logic        redirect;
  logic [15:0] redirect_pc;

  int n_chk;
  int n_fail;

  ccr_branch_unit u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    upd_mode = 2'd2; alu_flags = '0; wb_value = '0;
    cond_mask = '0; is_branch = 0; is_jump = 0;
  endtask

  // drive at negedge, take the edge, land on next negedge
  task automatic load_alu(input logic [3:0] f);
    @(negedge clk);
    upd_mode = 2'd0; alu_flags = f;
    @(negedge clk);
    idle();
    #1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    idle();
    imm_target = 16'h0000;
    rst_n = 0;
    #1;
    check("R1", {28'd0, flags}, 32'd0);
    repeat (3) @(negedge clk);
    check("R1", {28'd0, flags}, 32'd0);
    rst_n = 1;

    // R2/R5/R6/R7/R8 sweep
    for (int f = 0; f < 16; f++) begin
      load_alu(f[3:0]);
      check("R2", {28'd0, flags}, f);
      for (int m = 0; m < 16; m++) begin
        for (int q = 0; q < 4; q++) begin
          cond_mask  = m[3:0];
          is_branch  = q[0];
          is_jump    = q[1];
          imm_target = 16'(f * 4099 + m * 257 + q * 31);
          #1;
          if (q[1])      check("R5", {31'd0, redirect}, 1);
          else if (q[0]) check("R6", {31'd0, redirect}, ((m & f) != 0) ? 1 : 0);
          else           check("R7", {31'd0, redirect}, 0);
          check("R8", {16'd0, redirect_pc}, {16'd0, imm_target});
        end
      end
      idle();
    end

    // R3 write-back derivation
    for (int i = 0; i < 40; i++) begin
      logic [15:0] v;
      logic [3:0]  e;
      v = (i == 0) ? 16'h0000 : (i == 1) ? 16'h8000 : (i == 2) ? 16'hFFFF :
          (i == 3) ? 16'h0001 : 16'(i * 40503 + 7);
      load_alu(4'b1111);
      @(negedge clk);
      upd_mode = 2'd1; wb_value = v;
      @(negedge clk);
      idle();
      #1;
      e = {(v == 0), 1'b0, v[15], 1'b0};
      check("R3", {28'd0, flags}, {28'd0, e});
    end

    // R4 hold, modes 2 and 3, ALU inputs changing
    for (int md = 2; md < 4; md++) begin
      load_alu(4'b1010);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        upd_mode = md[1:0]; alu_flags = k[3:0] ^ 4'b0101; wb_value = 16'(k);
        @(negedge clk);
        #1;
        check("R4", {28'd0, flags}, 32'hA);
      end
      idle();
    end

    // R6 same-cycle update: branch sees old flags
    load_alu(4'b0000);
    @(negedge clk);
    upd_mode = 2'd0; alu_flags = 4'b1000; cond_mask = 4'b1000; is_branch = 1;
    #1;
    check("R6", {31'd0, redirect}, 0);
    @(negedge clk);
    #1;
    check("R2", {28'd0, flags}, 32'h8);
    check("R6", {31'd0, redirect}, 1);
    upd_mode = 2'd1; wb_value = 16'h0005;
    #1;
    check("R6", {31'd0, redirect}, 1);
    @(negedge clk);
    idle();
    is_branch = 1; cond_mask = 4'b1000;
    #1;
    check("R6", {31'd0, redirect}, 0);
    idle();

    // R1 asynchronous reset mid-run
    load_alu(4'b0111);
    #2;
    rst_n = 0;
    #1;
    check("R1", {28'd0, flags}, 32'd0);
    @(negedge clk);
    rst_n = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule